// File: doc/BRIEF.md
# Segmented Logical-to-Physical Address Mapper

This block widens a 16-bit logical address to a 20-bit physical address. The logical space is cut by its top nibble into four zones. The lowest zone passes through untranslated. A data zone and a stack zone sit above it, and their lower edges come from a programmable boundary register. A fixed 8K code window covers logical 0xE000 to 0xFFFF.

Each translated zone has its own 8-bit segment register. Translation adds that register to the top four address bits, and the low twelve bits pass through unchanged. Any carry out of the result is dropped, so physical addresses wrap within 1M.

A simple write port loads the boundary register and the three segment registers. A write becomes visible in the translation on the cycle after the clock edge that captured it. Translation itself is combinational. An I/O-space flag makes the block emit the logical address, zero-extended, whatever the register contents.

Top module: `seg_mapper`

## Requirements
- R1: After reset all four registers hold zero, so every logical address maps to itself zero-extended to 20 bits.
- R2: When address bits 15:12 are 0xE or 0xF, the window segment register is used, whatever the boundary values.
- R3: When bits 15:12 are at or above the stack start (boundary bits 7:4) and below 0xE, the stack segment register is used.
- R4: When bits 15:12 are at or above the data start (boundary bits 3:0) and below the stack start, the data segment register is used.
- R5: When bits 15:12 are below both the data start and the stack start, the physical address is the logical address zero-extended.
- R6: Translation sets physical bits 19:12 to (bits 15:12 + segment) mod 256 and copies bits 11:0, so a carry past bit 19 is lost.
- R7: While ioBypass is 1, the physical address is the logical address zero-extended.
- R8: Zone priority is window, then stack, then data, then root. A stack start at or below the data start gives the stack zone the overlap, and boundaries of 0xE or more never take the window's place.
- R9: A register write is seen at physAddr only after the capturing rising edge. With regWrEn at 0, no register changes.
- R10: regAddr selects the target register: 0 is the boundary, 1 is the data segment, 2 is the stack segment, 3 is the window segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 2 | Register select for a write |
| regWrData | input | 8 | Write data |
| logAddr | input | 16 | Logical address |
| ioBypass | input | 1 | I/O access, skips translation |
| physAddr | output | 20 | Physical address |

## Verification
A corrupted segment register shows up at once on physAddr[19:12] for every address in its zone, and leaves the low twelve bits and the other zones unaffected. A corrupted boundary register moves the zone edges instead, and that shows only for addresses whose top nibble lies between the correct edge and the faulty one. For this reason the vectors probe both sides of each edge. A write that lands in the wrong register, or on the wrong cycle, is visible in the first combinational sample after the edge.

// File: rtl/seg_mapper_pkg.sv
package seg_mapper_pkg;
  localparam int LOG_W   = 16;
  localparam int NIB_W   = 4;
  localparam int SEG_W   = 8;
  localparam int REG_AW  = 2;
  localparam int OFF_W   = LOG_W - NIB_W;
  localparam int PHYS_W  = OFF_W + SEG_W;
  localparam int BOUND_W = 2 * NIB_W;

  localparam logic [REG_AW-1:0] SEL_BOUND = 2'd0;
  localparam logic [REG_AW-1:0] SEL_DATA  = 2'd1;
  localparam logic [REG_AW-1:0] SEL_STACK = 2'd2;
  localparam logic [REG_AW-1:0] SEL_WIN   = 2'd3;

  typedef enum logic [1:0] {
    ZONE_ROOT  = 2'd0,
    ZONE_DATA  = 2'd1,
    ZONE_STACK = 2'd2,
    ZONE_WIN   = 2'd3
  } zone_e;

  typedef struct packed {
    logic wrBound;
    logic wrData;
    logic wrStack;
    logic wrWin;
  } wrStrobe_t;
endpackage

// File: rtl/seg_mapper_ctrl.sv
module seg_mapper_ctrl
  import seg_mapper_pkg::*;
(
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output wrStrobe_t         strobe
);
  // R10: register select decode
  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      case (regAddr)
        SEL_BOUND: strobe.wrBound = 1'b1;
        SEL_DATA:  strobe.wrData  = 1'b1;
        SEL_STACK: strobe.wrStack = 1'b1;
        SEL_WIN:   strobe.wrWin   = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/seg_mapper_zone.sv
module seg_mapper_zone
  import seg_mapper_pkg::*;
#(
  parameter int WIN_NIB = 14
) (
  input  logic [NIB_W-1:0]   pageNib,
  input  logic [BOUND_W-1:0] boundary,
  output zone_e              zone
);
  localparam logic [NIB_W-1:0] WIN_START = NIB_W'(WIN_NIB);

  logic [NIB_W-1:0] dataStart;
  logic [NIB_W-1:0] stackStart;

  assign dataStart  = boundary[NIB_W-1:0];
  assign stackStart = boundary[BOUND_W-1:NIB_W];

  // R8: window, then stack, then data, then root
  always_comb begin
    if (pageNib >= WIN_START)       zone = ZONE_WIN;
    else if (pageNib >= stackStart) zone = ZONE_STACK;
    else if (pageNib >= dataStart)  zone = ZONE_DATA;
    else                            zone = ZONE_ROOT;
  end
endmodule

// File: rtl/seg_mapper_dp.sv
module seg_mapper_dp
  import seg_mapper_pkg::*;
#(
  parameter int WIN_NIB = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          strobe,
  input  logic [SEG_W-1:0]   wrData,
  input  logic [LOG_W-1:0]   logAddr,
  input  logic               ioBypass,
  input  zone_e              zone,
  output logic [BOUND_W-1:0] boundOut,
  output logic [PHYS_W-1:0]  physAddr
);
  localparam logic [NIB_W-1:0] WIN_START = NIB_W'(WIN_NIB);

  logic [BOUND_W-1:0] boundReg;
  logic [SEG_W-1:0]   dataSeg;
  logic [SEG_W-1:0]   stackSeg;
  logic [SEG_W-1:0]   winSeg;
  logic [SEG_W-1:0]   segSel;
  logic [SEG_W-1:0]   pageBase;
  logic [NIB_W-1:0]   pageNib;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      boundReg <= '0;
      dataSeg  <= '0;
      stackSeg <= '0;
      winSeg   <= '0;
    end else begin
      if (strobe.wrBound) boundReg <= wrData[BOUND_W-1:0];
      if (strobe.wrData)  dataSeg  <= wrData;
      if (strobe.wrStack) stackSeg <= wrData;
      if (strobe.wrWin)   winSeg   <= wrData;
    end
  end

  assign boundOut = boundReg;
  assign pageNib  = logAddr[LOG_W-1:OFF_W];

  always_comb begin
    case (zone)
      ZONE_DATA:  segSel = dataSeg;
      ZONE_STACK: segSel = stackSeg;
      ZONE_WIN:   segSel = winSeg;
      default:    segSel = '0;
    endcase
    if (ioBypass) segSel = '0;
  end

  assign pageBase = {{(SEG_W-NIB_W){1'b0}}, pageNib} + segSel;
  assign physAddr = {pageBase, logAddr[OFF_W-1:0]};

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable({boundReg, dataSeg, stackSeg, winSeg}));

  assert_win_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrWin |=> (winSeg == $past(wrData)));

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rstN)
    ioBypass |-> (physAddr == {{(PHYS_W-LOG_W){1'b0}}, logAddr}));

  assert_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ioBypass && pageNib >= WIN_START) |->
      (physAddr[PHYS_W-1:OFF_W] == SEG_W'({{(SEG_W-NIB_W){1'b0}}, pageNib} + winSeg)));

  assert_stack_prio_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ioBypass && pageNib < WIN_START && pageNib >= boundReg[BOUND_W-1:NIB_W]) |->
      (physAddr[PHYS_W-1:OFF_W] == SEG_W'({{(SEG_W-NIB_W){1'b0}}, pageNib} + stackSeg)));

  assert_root_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ioBypass && pageNib < boundReg[NIB_W-1:0] && pageNib < boundReg[BOUND_W-1:NIB_W]) |->
      (physAddr == {{(PHYS_W-LOG_W){1'b0}}, logAddr}));
endmodule

// File: rtl/seg_mapper.sv
module seg_mapper
  import seg_mapper_pkg::*;
#(
  parameter int WIN_NIB = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [SEG_W-1:0]  regWrData,
  input  logic [LOG_W-1:0]  logAddr,
  input  logic              ioBypass,
  output logic [PHYS_W-1:0] physAddr
);
  wrStrobe_t          strobe;
  zone_e              zone;
  logic [BOUND_W-1:0] boundary;

  seg_mapper_ctrl i_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  seg_mapper_zone #(.WIN_NIB(WIN_NIB)) i_zone (
    .pageNib  (logAddr[LOG_W-1:OFF_W]),
    .boundary (boundary),
    .zone     (zone)
  );

  seg_mapper_dp #(.WIN_NIB(WIN_NIB)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .logAddr  (logAddr),
    .ioBypass (ioBypass),
    .zone     (zone),
    .boundOut (boundary),
    .physAddr (physAddr)
  );
endmodule

// File: tb/test_seg_mapper.sv
module test_seg_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [15:0] logAddr = '0;
  logic        ioBypass = 1'b0;
  logic [19:0] physAddr;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  seg_mapper i_seg_mapper (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .logAddr(logAddr), .ioBypass(ioBypass),
    .physAddr(physAddr)
  );

  typedef struct packed {
    logic [7:0]  bnd;
    logic [7:0]  dSeg;
    logic [7:0]  sSeg;
    logic [7:0]  wSeg;
    logic [15:0] addr;
    logic        byp;
    logic [19:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h64, 8'h10, 8'h20, 8'h75, 16'h1234, 1'b0, 20'h01234, 4'd5},  // R5 root
    '{8'h64, 8'h10, 8'h20, 8'h75, 16'h4ABC, 1'b0, 20'h14ABC, 4'd4},  // R4 data low edge
    '{8'h64, 8'h10, 8'h20, 8'h75, 16'h5FFF, 1'b0, 20'h15FFF, 4'd4},  // R4 data top
    '{8'h64, 8'h10, 8'h20, 8'h75, 16'h6000, 1'b0, 20'h26000, 4'd3},  // R3 stack low edge
    '{8'h64, 8'h10, 8'h20, 8'h75, 16'hDFFF, 1'b0, 20'h2DFFF, 4'd3},  // R3 stack top
    '{8'h64, 8'h10, 8'h20, 8'h75, 16'hE000, 1'b0, 20'h83000, 4'd2},  // R2 window start
    '{8'h64, 8'h10, 8'h20, 8'h75, 16'hF123, 1'b0, 20'h84123, 4'd2},  // R2 window top
    '{8'h64, 8'h10, 8'h20, 8'h75, 16'hF123, 1'b1, 20'h0F123, 4'd7},  // R7 bypass
    '{8'h64, 8'h10, 8'h20, 8'hF5, 16'hF456, 1'b0, 20'h04456, 4'd6},  // R6 wrap
    '{8'h35, 8'h10, 8'h20, 8'h75, 16'h4000, 1'b0, 20'h24000, 4'd8},  // R8 stack over data
    '{8'h35, 8'h10, 8'h20, 8'h75, 16'h2000, 1'b0, 20'h02000, 4'd8},  // R8 root below both
    '{8'hFE, 8'h10, 8'h20, 8'h75, 16'hE000, 1'b0, 20'h83000, 4'd8},  // R8 window beats boundaries
    '{8'hFE, 8'h10, 8'h20, 8'h75, 16'hD000, 1'b0, 20'h0D000, 4'd8}   // R8 root under high edges
  };

  task automatic check(input int req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: physAddr=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    // R1: identity during and right after reset
    logAddr = 16'hABCD;
    #5 check(1, physAddr, 20'h0ABCD);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    logAddr = 16'hFFFF; #1 check(1, physAddr, 20'h0FFFF);
    logAddr = 16'h7123; #1 check(1, physAddr, 20'h07123);

    // table walk; R10 register select exercised by every configuration
    for (int i = 0; i < NV; i++) begin
      writeReg(2'd0, VECS[i].bnd);
      writeReg(2'd1, VECS[i].dSeg);
      writeReg(2'd2, VECS[i].sSeg);
      writeReg(2'd3, VECS[i].wSeg);
      logAddr = VECS[i].addr;
      ioBypass = VECS[i].byp;
      #1 check(int'(VECS[i].req), physAddr, VECS[i].exp);
      ioBypass = 1'b0;
    end

    // R9: write timing and disabled writes
    writeReg(2'd0, 8'h64);
    writeReg(2'd3, 8'h75);
    writeReg(2'd1, 8'h10);
    @(negedge clk);
    logAddr = 16'h4000;
    regWrEn = 1'b1; regAddr = 2'd1; regWrData = 8'h40;
    #1 check(9, physAddr, 20'h14000);
    @(posedge clk); #1;
    check(9, physAddr, 20'h44000);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd1; regWrData = 8'h99;
    @(posedge clk); #1;
    check(9, physAddr, 20'h44000);
    // R10: boundary register at select 0 moves the data edge
    writeReg(2'd0, 8'h63);
    logAddr = 16'h3000; #1 check(10, physAddr, 20'h43000);
    // R7: bypass overrides a window translation
    logAddr = 16'hE000; ioBypass = 1'b1; #1 check(7, physAddr, 20'h0E000);
    ioBypass = 1'b0; #1 check(2, physAddr, 20'h83000);
    finishRun();
  end
endmodule